// File: doc/BRIEF.md
# Four-Channel DMA Register File and Transfer Engine

This block holds the programming state of four DMA channels and sequences single-mode transfers for them. A host reaches every register through an 8-bit data port and a 5-bit port address. Each channel has a 16-bit address counter and a 16-bit transfer counter. Each of these sits behind one port and takes two byte accesses. A byte pointer flip-flop, shared by all channels, decides whether an access hits the low or the high byte. Each channel also has an 8-bit page register, a mode and a mask bit.

A device asks for service by holding its request line. The engine grants one channel at a time with a one-cycle acknowledge pulse. For a normal transfer it presents the 24-bit memory address (page above the 16-bit counter) and then steps the address and the count. When the count is exhausted it flags terminal count and pulses an end-of-process output. The channel then either masks itself or reloads its programmed start values. A channel set to cascade mode only receives acknowledge pulses. It drives no address and keeps its counters still.

Top module: `dma_core`

## Requirements
- R1: Port 2n holds channel n's address and port 2n+1 its count (n = 0..3). The byte pointer starts in the low state. Every read or write of these eight ports uses the low byte when the pointer is low and the high byte when it is high, then toggles the pointer. Reads return the current values.
- R2: A write of any data to port 0x0B returns the byte pointer to the low state.
- R3: A programmed count k produces exactly k+1 address-driving grants before the channel stops. A step that is not terminal decrements the count by one.
- R4: A write to port 0x09 selects channel hwdata[1:0]. When hwdata[2] is 1 it masks that channel, and when it is 0 it unmasks it. A masked channel receives no acknowledge.
- R5: A write to port 0x0A sets the mode of channel hwdata[1:0]. Bits 3:2 = 10 mean memory-to-device (mem_to_dev high) and 01 mean device-to-memory. Bit 5 selects address decrement instead of increment. Bit 4 enables auto-reload. Bits 7:6 = 11 select cascade, where a grant gives an acknowledge with addr_valid low and no change to address or count.
- R6: mem_addr equals {page, address counter}. Port 0x10+n writes channel n's page and reads it back. The 16-bit counter wraps (0xFFFF to 0x0000 on increment) without changing the page.
- R7: A grant appears as a one-hot dack pulse in the cycle after the request is sampled, for a channel that was requesting and unmasked. No grant is issued in the cycle right after a grant.
- R8: Among simultaneous unmasked requests, the lowest channel number is granted.
- R9: A grant with count 0x0000 is terminal. It raises eop with that transfer, sets the channel's terminal flag and leaves the count at 0xFFFF. Without auto-reload it also masks the channel.
- R10: With auto-reload, a terminal grant restores address and count to the last programmed values and leaves the channel unmasked.
- R11: Reading port 0x08 returns {dreq[3:0], terminal flags[3:0]} and clears the terminal flags. A flag set in the same cycle is kept.
- R12: Reset and a write to port 0x0C (master clear) set all masks, clear all modes and terminal flags, and put the pointer low. Port 0x0D unmasks all channels. Port 0x0E loads all four masks from hwdata[3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hwr | input | 1 | Host write strobe, one cycle per access |
| hrd | input | 1 | Host read strobe, one cycle per access |
| haddr | input | 5 | Host port address |
| hwdata | input | 8 | Host write data |
| hrdata | output | 8 | Host read data, valid while hrd is high |
| dreq | input | 4 | Per-channel service request |
| dack | output | 4 | Per-channel one-cycle acknowledge |
| mem_addr | output | 24 | Address of the current transfer |
| addr_valid | output | 1 | mem_addr is driven for this acknowledge |
| mem_to_dev | output | 1 | Direction of the current transfer |
| eop | output | 1 | Terminal transfer of a channel |

## Verification
The assertions check the grant rules on every cycle: dack is one-hot, a grant is never followed directly by another, and it only goes to a channel that was requesting. No lower unmasked requester is ever passed over. eop only occurs with a driven address. The count steps by one, a non-reload terminal grant masks the channel, and auto-reload restores the programmed values. The byte-pointer sequencing, the read-back values, the page wrap, the status clearing, the cascade behaviour and the mask ports can only be shown by the bench's scenarios. In those scenarios a behavioural model predicts every output and every read byte.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef struct packed {
    logic cascade;
    logic autoinit;
    logic decr;
    logic to_dev;
  } chan_mode_t;

  localparam logic [4:0] PORT_STATUS     = 5'h08;
  localparam logic [4:0] PORT_MASK_ONE   = 5'h09;
  localparam logic [4:0] PORT_MODE       = 5'h0A;
  localparam logic [4:0] PORT_PTR_CLR    = 5'h0B;
  localparam logic [4:0] PORT_MCLR       = 5'h0C;
  localparam logic [4:0] PORT_UNMASK_ALL = 5'h0D;
  localparam logic [4:0] PORT_MASK_ALL   = 5'h0E;
  localparam logic [4:0] PORT_PAGE_BASE  = 5'h10;

  function automatic chan_mode_t decode_mode(input logic [7:0] d);
    chan_mode_t m;
    m.cascade  = (d[7:6] == 2'b11);
    m.autoinit = d[4];
    m.decr     = d[5];
    m.to_dev   = (d[3:2] == 2'b10);
    return m;
  endfunction

endpackage

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  input  logic         en,
  output logic [N-1:0] gnt
);

  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (en && req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mclr,
  input  logic          wr_addr_lo,
  input  logic          wr_addr_hi,
  input  logic          wr_cnt_lo,
  input  logic          wr_cnt_hi,
  input  logic          wr_page,
  input  logic          wr_mode,
  input  logic [7:0]    wdata,
  input  chan_mode_t    mode_in,
  input  logic          mask_set,
  input  logic          mask_clr,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] cur_cnt,
  output logic [PW-1:0] page,
  output chan_mode_t    mode,
  output logic          masked,
  output logic          tc_hit
);

  localparam int HB = AW - 8;
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] addr_q, addr_d, cnt_q, cnt_d;
  logic [AW-1:0] base_addr_q, base_addr_d, base_cnt_q, base_cnt_d;
  logic [PW-1:0] page_q, page_d;
  chan_mode_t    mode_q, mode_d;
  logic          mask_q, mask_d;

  assign tc_hit = step && (cnt_q == '0);

  always_comb begin
    addr_d      = addr_q;
    cnt_d       = cnt_q;
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    page_d      = page_q;
    if (step) begin
      if (tc_hit && mode_q.autoinit) begin
        addr_d = base_addr_q;
        cnt_d  = base_cnt_q;
      end else begin
        addr_d = mode_q.decr ? addr_q - ONE : addr_q + ONE;
        cnt_d  = cnt_q - ONE;
      end
    end
    if (wr_addr_lo) begin
      base_addr_d[7:0] = wdata;
      addr_d[7:0]      = wdata;
    end
    if (wr_addr_hi) begin
      base_addr_d[AW-1:8] = wdata[HB-1:0];
      addr_d[AW-1:8]      = wdata[HB-1:0];
    end
    if (wr_cnt_lo) begin
      base_cnt_d[7:0] = wdata;
      cnt_d[7:0]      = wdata;
    end
    if (wr_cnt_hi) begin
      base_cnt_d[AW-1:8] = wdata[HB-1:0];
      cnt_d[AW-1:8]      = wdata[HB-1:0];
    end
    if (wr_page) page_d = wdata[PW-1:0];
    if (mclr)         mode_d = '0;
    else if (wr_mode) mode_d = mode_in;
    else              mode_d = mode_q;
    if (mclr || mask_set)                 mask_d = 1'b1;
    else if (mask_clr)                    mask_d = 1'b0;
    else if (tc_hit && !mode_q.autoinit)  mask_d = 1'b1;
    else                                  mask_d = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      cnt_q       <= '0;
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      page_q      <= '0;
      mode_q      <= '0;
      mask_q      <= 1'b1;
    end else begin
      addr_q      <= addr_d;
      cnt_q       <= cnt_d;
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      page_q      <= page_d;
      mode_q      <= mode_d;
      mask_q      <= mask_d;
    end
  end

  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;
  assign page     = page_q;
  assign mode     = mode_q;
  assign masked   = mask_q;

  logic wr_cnt_any, wr_any;
  assign wr_cnt_any = wr_cnt_lo || wr_cnt_hi;
  assign wr_any     = wr_cnt_any || wr_addr_lo || wr_addr_hi;

  // R3: a non-terminal step lowers the count by exactly one
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q != '0 && !wr_cnt_any) |=> (cnt_q == $past(cnt_q) - ONE));

  // R9: terminal grant without reload masks the channel
  assert_tc_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q == '0 && !mode_q.autoinit && !mask_clr) |=> mask_q);

  // R10: terminal grant with reload restores the programmed values
  assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q == '0 && mode_q.autoinit && !wr_any)
      |=> (cnt_q == $past(base_cnt_q) && addr_q == $past(base_addr_q) && !mask_q));

  // R6: page only changes through its own port
  assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_page) |=> (page_q == $past(page_q)));

endmodule

// File: rtl/dma_core.sv
module dma_core
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int PW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hwr,
  input  logic             hrd,
  input  logic [4:0]       haddr,
  input  logic [7:0]       hwdata,
  output logic [7:0]       hrdata,
  input  logic [NCH-1:0]   dreq,
  output logic [NCH-1:0]   dack,
  output logic [AW+PW-1:0] mem_addr,
  output logic             addr_valid,
  output logic             mem_to_dev,
  output logic             eop
);

  localparam int CW  = $clog2(NCH);
  localparam int MAW = AW + PW;

  // host decode
  logic          chan_port, is_cnt, mclr, ptr_clr, status_rd;
  logic [CW-1:0] acc_ch;
  assign chan_port = (haddr < 5'(2 * NCH));
  assign is_cnt    = haddr[0];
  assign acc_ch    = haddr[CW:1];
  assign mclr      = hwr && (haddr == PORT_MCLR);
  assign ptr_clr   = hwr && (haddr == PORT_PTR_CLR);
  assign status_rd = hrd && (haddr == PORT_STATUS);

  logic ff_q, ff_d;
  logic [NCH-1:0] tc_q, tc_d;
  logic [NCH-1:0] dack_q, dack_d;
  logic [MAW-1:0] maddr_q, maddr_d;
  logic valid_q, valid_d, eop_q, eop_d, dir_q, dir_d;

  logic [AW-1:0]  ch_addr [NCH];
  logic [AW-1:0]  ch_cnt  [NCH];
  logic [PW-1:0]  ch_page [NCH];
  chan_mode_t     ch_mode [NCH];
  logic [NCH-1:0] ch_mask, ch_tc, ch_casc, step, gnt, req_ok;
  chan_mode_t     mode_in;

  assign mode_in = decode_mode(hwdata);
  assign req_ok  = dreq & ~ch_mask;

  dma_arb #(.N(NCH)) u_arb (.req(req_ok), .en(dack_q == '0), .gnt(gnt));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel, wr_ch, msel;
    assign sel   = (acc_ch == CW'(i));
    assign wr_ch = hwr && chan_port && sel;
    assign msel  = (hwdata[CW-1:0] == CW'(i));
    assign ch_casc[i] = ch_mode[i].cascade;
    assign step[i]    = gnt[i] && !ch_mode[i].cascade;

    dma_chan #(.AW(AW), .PW(PW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .mclr      (mclr),
      .wr_addr_lo(wr_ch && !is_cnt && !ff_q),
      .wr_addr_hi(wr_ch && !is_cnt &&  ff_q),
      .wr_cnt_lo (wr_ch &&  is_cnt && !ff_q),
      .wr_cnt_hi (wr_ch &&  is_cnt &&  ff_q),
      .wr_page   (hwr && (haddr == PORT_PAGE_BASE + 5'(i))),
      .wr_mode   (hwr && (haddr == PORT_MODE) && msel),
      .wdata     (hwdata),
      .mode_in   (mode_in),
      .mask_set  (hwr && (((haddr == PORT_MASK_ONE) && msel && hwdata[2]) ||
                          ((haddr == PORT_MASK_ALL) && hwdata[i]))),
      .mask_clr  (hwr && (((haddr == PORT_MASK_ONE) && msel && !hwdata[2]) ||
                          (haddr == PORT_UNMASK_ALL) ||
                          ((haddr == PORT_MASK_ALL) && !hwdata[i]))),
      .step      (step[i]),
      .cur_addr  (ch_addr[i]),
      .cur_cnt   (ch_cnt[i]),
      .page      (ch_page[i]),
      .mode      (ch_mode[i]),
      .masked    (ch_mask[i]),
      .tc_hit    (ch_tc[i])
    );
  end

  // read mux
  logic [AW-1:0] rd_word;
  always_comb begin
    rd_word = is_cnt ? ch_cnt[acc_ch] : ch_addr[acc_ch];
    hrdata  = '0;
    if (chan_port)                  hrdata = ff_q ? rd_word[AW-1:8] : rd_word[7:0];
    else if (haddr == PORT_STATUS)  hrdata = {dreq, tc_q};
    else begin
      for (int i = 0; i < NCH; i++)
        if (haddr == PORT_PAGE_BASE + 5'(i)) hrdata = ch_page[i];
    end
  end

  // winner data
  logic [MAW-1:0] win_addr;
  logic           win_dir;
  always_comb begin
    win_addr = maddr_q;
    win_dir  = dir_q;
    for (int i = 0; i < NCH; i++) begin
      if (gnt[i]) begin
        win_addr = {ch_page[i], ch_addr[i]};
        win_dir  = ch_mode[i].to_dev;
      end
    end
  end

  // next state
  always_comb begin
    if (mclr || ptr_clr)                 ff_d = 1'b0;
    else if (chan_port && (hwr || hrd))  ff_d = !ff_q;
    else                                 ff_d = ff_q;
    tc_d    = mclr ? '0 : ((status_rd ? '0 : tc_q) | ch_tc);
    dack_d  = gnt;
    valid_d = |(gnt & ~ch_casc);
    eop_d   = |ch_tc;
    maddr_d = win_addr;
    dir_d   = win_dir;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q    <= 1'b0;
      tc_q    <= '0;
      dack_q  <= '0;
      maddr_q <= '0;
      valid_q <= 1'b0;
      eop_q   <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      ff_q    <= ff_d;
      tc_q    <= tc_d;
      dack_q  <= dack_d;
      valid_q <= valid_d;
      eop_q   <= eop_d;
      if (|gnt) begin
        maddr_q <= maddr_d;
        dir_q   <= dir_d;
      end
    end
  end

  assign dack       = dack_q;
  assign mem_addr   = maddr_q;
  assign addr_valid = valid_q;
  assign mem_to_dev = dir_q;
  assign eop        = eop_q;

  assert_onehot_dack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack_q));

  assert_grant_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_q != '0) |=> (dack_q == '0));

  assert_grant_requested_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_q != '0) |-> ((dack_q & ~$past(req_ok)) == '0));

  assert_lowest_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_q != '0) |-> (($past(req_ok) & (dack_q - NCH'(1))) == '0));

  assert_eop_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eop_q |-> (valid_q && dack_q != '0));

endmodule

// File: tb/test_dma_core.sv
module test_dma_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hwr = 1'b0, hrd = 1'b0;
  logic [4:0]  haddr = '0;
  logic [7:0]  hwdata = '0;
  logic [7:0]  hrdata;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack;
  logic [23:0] mem_addr;
  logic        addr_valid, mem_to_dev, eop;

  always #10 clk = ~clk;

  dma_core i_dma_core (
    .clk(clk), .rst_n(rst_n), .hwr(hwr), .hrd(hrd), .haddr(haddr),
    .hwdata(hwdata), .hrdata(hrdata), .dreq(dreq), .dack(dack),
    .mem_addr(mem_addr), .addr_valid(addr_valid), .mem_to_dev(mem_to_dev),
    .eop(eop)
  );

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_addr [4], m_cnt [4], m_baddr [4], m_bcnt [4];
  logic [7:0]  m_page [4];
  bit          m_casc [4], m_auto [4], m_dec [4], m_dev [4];
  logic [3:0]  m_mask, m_tc, m_dack;
  bit          m_ff, m_valid, m_eop, m_dir;
  logic [23:0] m_maddr;

  always @(posedge clk or negedge rst_n) begin
    int w, c;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_addr[i] = 0; m_cnt[i] = 0; m_baddr[i] = 0; m_bcnt[i] = 0; m_page[i] = 0;
        m_casc[i] = 0; m_auto[i] = 0; m_dec[i] = 0; m_dev[i] = 0;
      end
      m_mask = 4'hF; m_tc = 0; m_dack = 0; m_ff = 0;
      m_valid = 0; m_eop = 0; m_dir = 0; m_maddr = 0;
    end else begin
      w = -1;
      if (m_dack == 0)
        for (int i = 3; i >= 0; i--) if (dreq[i] && !m_mask[i]) w = i;
      if (hrd && haddr == 5'h08) m_tc = 0;
      m_dack = 0; m_valid = 0; m_eop = 0;
      if (w >= 0) begin
        m_dack[w] = 1'b1;
        m_maddr = {m_page[w], m_addr[w]};
        m_dir = m_dev[w];
        if (!m_casc[w]) begin
          m_valid = 1;
          if (m_cnt[w] == 0) begin
            m_eop = 1; m_tc[w] = 1'b1;
            if (m_auto[w]) begin m_addr[w] = m_baddr[w]; m_cnt[w] = m_bcnt[w]; end
            else begin
              m_cnt[w] = 16'hFFFF; m_mask[w] = 1'b1;
              m_addr[w] = m_dec[w] ? m_addr[w] - 1 : m_addr[w] + 1;
            end
          end else begin
            m_cnt[w] = m_cnt[w] - 1;
            m_addr[w] = m_dec[w] ? m_addr[w] - 1 : m_addr[w] + 1;
          end
        end
      end
      if (hwr) begin
        c = hwdata[1:0];
        if (haddr < 8) begin
          c = haddr >> 1;
          if (haddr[0]) begin
            if (m_ff) begin m_cnt[c][15:8] = hwdata; m_bcnt[c][15:8] = hwdata; end
            else      begin m_cnt[c][7:0]  = hwdata; m_bcnt[c][7:0]  = hwdata; end
          end else begin
            if (m_ff) begin m_addr[c][15:8] = hwdata; m_baddr[c][15:8] = hwdata; end
            else      begin m_addr[c][7:0]  = hwdata; m_baddr[c][7:0]  = hwdata; end
          end
        end
        case (haddr)
          5'h09: m_mask[c] = hwdata[2];
          5'h0A: begin
            m_casc[c] = (hwdata[7:6] == 2'b11); m_auto[c] = hwdata[4];
            m_dec[c] = hwdata[5]; m_dev[c] = (hwdata[3:2] == 2'b10);
          end
          5'h0C: begin
            m_mask = 4'hF; m_tc = 0;
            for (int i = 0; i < 4; i++) begin m_casc[i]=0; m_auto[i]=0; m_dec[i]=0; m_dev[i]=0; end
          end
          5'h0D: m_mask = 0;
          5'h0E: m_mask = hwdata[3:0];
          5'h10, 5'h11, 5'h12, 5'h13: m_page[haddr[1:0]] = hwdata;
          default: ;
        endcase
      end
      if (hwr && (haddr == 5'h0B || haddr == 5'h0C)) m_ff = 0;
      else if ((hwr || hrd) && haddr < 8) m_ff = !m_ff;
    end
  end

  function automatic logic [7:0] m_rd(input logic [4:0] a);
    logic [15:0] v;
    if (a < 8) begin
      v = a[0] ? m_cnt[a >> 1] : m_addr[a >> 1];
      return m_ff ? v[15:8] : v[7:0];
    end
    if (a == 5'h08) return {dreq, m_tc};
    if (a >= 5'h10 && a <= 5'h13) return m_page[a[1:0]];
    return 8'h00;
  endfunction

  // per-cycle comparison and grant monitor
  int gcount [4], vcount [4];
  logic [23:0] last_addr [4];

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(dack == m_dack, "R7 dack", dack, m_dack);
      chk(mem_addr == m_maddr, "R6 mem_addr", mem_addr, m_maddr);
      chk(addr_valid == m_valid, "R5 addr_valid", addr_valid, m_valid);
      chk(eop == m_eop, "R9 eop", eop, m_eop);
      chk(mem_to_dev == m_dir, "R5 mem_to_dev", mem_to_dev, m_dir);
      for (int i = 0; i < 4; i++) if (dack[i]) begin
        gcount[i]++;
        if (addr_valid) begin vcount[i]++; last_addr[i] = mem_addr; end
      end
    end
  end

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog R7 actual=%0d expected=below 20000 cycles", cyc);
      report();
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    haddr = a; hwdata = d; hwr = 1'b1;
    @(negedge clk);
    hwr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input string tag, input int exp);
    logic [7:0] e;
    haddr = a; hrd = 1'b1;
    #1;
    e = m_rd(a);
    chk(hrdata == e, {tag, " model"}, hrdata, e);
    if (exp >= 0) chk(hrdata == 8'(exp), tag, hrdata, exp);
    @(negedge clk);
    hrd = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [7:0] pg, input logic [15:0] ad,
                      input logic [15:0] cn, input logic [7:0] md);
    wr(5'h0B, 8'h00);
    wr(5'(16 + ch), pg);
    wr(5'(2 * ch), ad[7:0]);
    wr(5'(2 * ch), ad[15:8]);
    wr(5'(2 * ch + 1), cn[7:0]);
    wr(5'(2 * ch + 1), cn[15:8]);
    wr(5'h0A, md | 8'(ch));
  endtask

  task automatic clr_counts;
    for (int i = 0; i < 4; i++) begin gcount[i] = 0; vcount[i] = 0; end
  endtask

  initial begin
    clr_counts();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk(dack == 0, "R12 reset dack", dack, 0);
    rd(5'h08, "R12 reset status", 0);
    dreq = 4'hF; idle(4);
    chk(gcount[0] + gcount[1] + gcount[2] + gcount[3] == 0, "R12 reset masks", gcount[0], 0);
    dreq = 0; idle(1);

    // R3 R9 basic run on channel 1
    prog(1, 8'h12, 16'h3400, 16'h0002, 8'h44);
    wr(5'h09, 8'h01);
    clr_counts();
    dreq = 4'b0010; idle(12);
    chk(gcount[1] == 3, "R3 transfer count", gcount[1], 3);
    chk(last_addr[1] == 24'h123402, "R6 last address", last_addr[1], 24'h123402);
    rd(5'h08, "R11 status with tc", 8'h22);
    clr_counts(); idle(4);
    chk(gcount[1] == 0, "R9 masked after tc", gcount[1], 0);
    dreq = 0;
    rd(5'h08, "R11 status cleared", 8'h00);
    rd(5'h03, "R9 count lo after tc", 8'hFF);
    rd(5'h03, "R1 count hi", 8'hFF);
    rd(5'h02, "R1 addr lo", 8'h03);
    rd(5'h02, "R1 addr hi", 8'h34);
    rd(5'h11, "R6 page readback", 8'h12);

    // R2 pointer clear
    wr(5'h00, 8'hAA);
    wr(5'h0B, 8'h5A);
    wr(5'h00, 8'h11);
    wr(5'h00, 8'h22);
    rd(5'h00, "R2 lo after clear", 8'h11);
    rd(5'h00, "R2 hi after clear", 8'h22);
    rd(5'h00, "R1 lo again", 8'h11);
    wr(5'h0B, 8'hFF);
    rd(5'h00, "R2 read restart", 8'h11);
    wr(5'h0B, 8'h00);

    // R6 wrap inside the page
    prog(2, 8'h05, 16'hFFFF, 16'h0001, 8'h44);
    wr(5'h09, 8'h02);
    clr_counts();
    dreq = 4'b0100; idle(8);
    chk(gcount[2] == 2, "R3 two transfers", gcount[2], 2);
    chk(last_addr[2] == 24'h050000, "R6 wrap keeps page", last_addr[2], 24'h050000);
    chk(mem_to_dev == 0, "R5 device to memory", mem_to_dev, 0);
    dreq = 0; idle(1);

    // R8 priority
    prog(0, 8'h00, 16'h0100, 16'h0005, 8'h44);
    prog(3, 8'h00, 16'h0200, 16'h0005, 8'h44);
    dreq = 4'b1001; idle(1);
    clr_counts();
    wr(5'h0D, 8'h00);
    idle(8);
    chk(gcount[3] == 0, "R8 lower channel wins", gcount[3], 0);
    chk(gcount[0] >= 3, "R8 channel 0 served", gcount[0], 3);
    dreq = 4'b1000; idle(4);
    chk(gcount[3] >= 1, "R8 channel 3 after release", gcount[3], 1);
    dreq = 0; idle(2);

    // R10 auto-reload
    prog(1, 8'h12, 16'h0010, 16'h0001, 8'h54);
    wr(5'h09, 8'h01);
    clr_counts();
    dreq = 4'b0010; idle(12);
    chk(gcount[1] >= 5, "R10 reload keeps channel live", gcount[1], 5);
    dreq = 0; idle(2);
    rd(5'h08, "R11 status after reload", -1);

    // R5 decrement, memory to device
    prog(0, 8'h00, 16'h0005, 16'h0002, 8'h68);
    wr(5'h09, 8'h00);
    clr_counts();
    dreq = 4'b0001; idle(8);
    chk(gcount[0] == 3, "R5 decrement run length", gcount[0], 3);
    chk(last_addr[0] == 24'h000003, "R5 decrement address", last_addr[0], 24'h000003);
    chk(mem_to_dev == 1, "R5 memory to device", mem_to_dev, 1);
    dreq = 0; idle(2);

    // R5 cascade
    prog(2, 8'h05, 16'h1234, 16'h0000, 8'hC0);
    wr(5'h09, 8'h02);
    clr_counts();
    dreq = 4'b0100; idle(6);
    chk(gcount[2] >= 2, "R5 cascade acknowledged", gcount[2], 2);
    chk(vcount[2] == 0, "R5 cascade drives no address", vcount[2], 0);
    dreq = 0; idle(2);
    rd(5'h04, "R5 cascade addr lo unchanged", 8'h34);
    rd(5'h04, "R5 cascade addr hi unchanged", 8'h12);
    rd(5'h05, "R5 cascade count lo unchanged", 8'h00);
    rd(5'h05, "R5 cascade count hi unchanged", 8'h00);

    // R12 all-mask port, R4 single mask
    wr(5'h0E, 8'h0F);
    clr_counts();
    dreq = 4'hF; idle(4);
    chk(gcount[0] + gcount[1] + gcount[2] + gcount[3] == 0, "R12 mask all", gcount[2], 0);
    wr(5'h0E, 8'h0B);
    clr_counts(); idle(4);
    chk(gcount[2] >= 1, "R12 mask field unmasks bit 2", gcount[2], 1);
    chk(gcount[0] == 0, "R12 mask field keeps bit 0", gcount[0], 0);
    wr(5'h09, 8'h06);
    idle(2);
    clr_counts(); idle(4);
    chk(gcount[2] == 0, "R4 single mask set", gcount[2], 0);
    wr(5'h09, 8'h02);
    clr_counts(); idle(4);
    chk(gcount[2] >= 1, "R4 single mask clear", gcount[2], 1);
    dreq = 0; idle(2);

    // R12 master clear
    wr(5'h00, 8'h77);
    wr(5'h0C, 8'h00);
    rd(5'h00, "R12 pointer low after master clear", 8'h77);
    wr(5'h0B, 8'h00);
    rd(5'h08, "R12 flags cleared", 8'h00);
    clr_counts();
    dreq = 4'hF; idle(4);
    chk(gcount[0] + gcount[1] + gcount[2] + gcount[3] == 0, "R12 masks set by clear", gcount[0], 0);
    dreq = 0; idle(2);

    done = 1;
    report();
    $finish;
  end

endmodule